// File: doc/BRIEF.md
# Redundant Channel Output Checker

This block watches the output flags of two neighbouring timer channels that are programmed to produce the same waveform. It is a functional-safety monitor. Both flags are captured in a register stage and compared there. If they ever differ, a sticky fault flag is set and an interrupt request is raised. From then on both outputs are held at their programmed inactive levels until software clears the fault and the flags agree again.

For self-test, each channel has a force strobe and a force value. While a channel's strobe is high, its force value replaces its raw flag at the capture stage. Software can use this to create a deliberate disagreement and confirm that the checker reacts. When the checker is disabled, both raw flags reach the outputs unchanged and no fault is kept.

Top module: `redundant_pair_checker`

## Requirements
- R1: While reset is low, the fault flag and the interrupt are 0 and both capture registers are 0, so with enable high and no fault each output is 0 regardless of its inactive level.
- R2: With enable high and no fault, each output equals that channel's raw flag as it stood at the previous rising clock edge (one cycle of latency).
- R3: If the two captured values differ at a rising edge while enable is high, the fault flag is 1 after that edge. The fault therefore appears one clock after the capture edge that recorded the disagreement.
- R4: The fault flag is sticky. It returns to 0 only at an edge where the fault-clear input is 1 and the captured values agree. A disagreement at the same edge takes priority, and the flag stays set.
- R5: While enable is high and the fault flag is 1, output A equals inactive level A and output B equals inactive level B.
- R6: The interrupt request is high in exactly the cycles where the fault flag is high.
- R7: When a channel's force strobe is 1 at a rising edge, that channel's capture register takes its force value instead of its raw flag. This can be used to inject a mismatch.
- R8: While enable is 0, each output follows its raw flag combinationally. At the next edge the fault flag is 0, and it does not set while the checker stays disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset |
| enable | input | 1 | 1 = checking active, 0 = pass raw flags through |
| ch_a_raw | input | 1 | Raw output flag of channel A |
| ch_b_raw | input | 1 | Raw output flag of channel B |
| idle_a | input | 1 | Inactive level for output A |
| idle_b | input | 1 | Inactive level for output B |
| frc_a_stb | input | 1 | Force strobe for channel A |
| frc_a_val | input | 1 | Force value for channel A |
| frc_b_stb | input | 1 | Force strobe for channel B |
| frc_b_val | input | 1 | Force value for channel B |
| flt_clr | input | 1 | Write-one-to-clear for the fault flag |
| out_a | output | 1 | Gated output of channel A |
| out_b | output | 1 | Gated output of channel B |
| flt | output | 1 | Sticky redundancy-fault flag |
| irq | output | 1 | Interrupt request |

## Verification
Timing of each result, counted from the rising edge at which the inputs are sampled:
- The captured flags appear on the outputs right after that first edge.
- A disagreement raises the fault and gates the outputs only after the second edge.
- A clear, or a disable, lowers the fault after the first edge.
- The disabled pass-through has no delay at all.

The bench applies each stimulus at a falling edge and runs a reference model that computes what the outputs should be after the next rising edge. It queues that expected value. A monitor compares the queued value 2 ns after the edge, so every comparison lands in the cycle in which the result is due.

// File: rtl/redundant_pair_checker.sv
module redundant_pair_checker (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic ch_a_raw,
  input  logic ch_b_raw,
  input  logic idle_a,
  input  logic idle_b,
  input  logic frc_a_stb,
  input  logic frc_a_val,
  input  logic frc_b_stb,
  input  logic frc_b_val,
  input  logic flt_clr,
  output logic out_a,
  output logic out_b,
  output logic flt,
  output logic irq
);

  logic q_a, q_b, flt_q;
  logic mismatch;

  assign mismatch = q_a ^ q_b;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_a   <= 1'b0;
      q_b   <= 1'b0;
      flt_q <= 1'b0;
    end else begin
      q_a <= frc_a_stb ? frc_a_val : ch_a_raw;
      q_b <= frc_b_stb ? frc_b_val : ch_b_raw;
      if (!enable)
        flt_q <= 1'b0;
      else if (mismatch)
        flt_q <= 1'b1;
      else if (flt_clr)
        flt_q <= 1'b0;
    end
  end

  assign out_a = !enable ? ch_a_raw : (flt_q ? idle_a : q_a);
  assign out_b = !enable ? ch_b_raw : (flt_q ? idle_b : q_b);
  assign flt   = flt_q;
  assign irq   = flt_q;

endmodule

module redundant_pair_checker_sva (
  input logic clk,
  input logic rst_n,
  input logic enable,
  input logic idle_a,
  input logic idle_b,
  input logic ch_a_raw,
  input logic ch_b_raw,
  input logic flt_clr,
  input logic q_a,
  input logic q_b,
  input logic out_a,
  input logic out_b,
  input logic flt,
  input logic irq
);

  always_comb begin
    if (!rst_n) a_r1_reset_clear: assert (!flt && !irq);
  end

  a_r3_mismatch_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && (q_a != q_b)) |=> flt);

  a_r4_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && flt && !flt_clr) |=> flt);

  a_r4_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && flt && flt_clr && (q_a == q_b)) |=> !flt);

  a_r5_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && flt) |-> (out_a == idle_a && out_b == idle_b));

  a_r6_irq_follows: assert property (@(posedge clk) disable iff (!rst_n)
    irq == flt);

  a_r8_bypass: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |-> (out_a == ch_a_raw && out_b == ch_b_raw));

  a_r8_no_fault: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !flt);

endmodule

bind redundant_pair_checker redundant_pair_checker_sva u_sva (
  .clk(clk), .rst_n(rst_n), .enable(enable), .idle_a(idle_a), .idle_b(idle_b),
  .ch_a_raw(ch_a_raw), .ch_b_raw(ch_b_raw), .flt_clr(flt_clr),
  .q_a(q_a), .q_b(q_b), .out_a(out_a), .out_b(out_b), .flt(flt), .irq(irq)
);

// File: tb/sim_redundant_pair_checker.sv
module sim_redundant_pair_checker;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b1, ch_a_raw = 1'b0, ch_b_raw = 1'b0;
  logic idle_a = 1'b1, idle_b = 1'b0;
  logic frc_a_stb = 1'b0, frc_a_val = 1'b0, frc_b_stb = 1'b0, frc_b_val = 1'b0;
  logic flt_clr = 1'b0;
  logic out_a, out_b, flt, irq;

  always #4 clk = ~clk;

  redundant_pair_checker u0 (
    .clk(clk), .rst_n(rst_n), .enable(enable), .ch_a_raw(ch_a_raw), .ch_b_raw(ch_b_raw),
    .idle_a(idle_a), .idle_b(idle_b), .frc_a_stb(frc_a_stb), .frc_a_val(frc_a_val),
    .frc_b_stb(frc_b_stb), .frc_b_val(frc_b_val), .flt_clr(flt_clr),
    .out_a(out_a), .out_b(out_b), .flt(flt), .irq(irq)
  );

  typedef struct {
    string tag;
    logic  ea, eb, ef;
  } exp_t;

  exp_t sb[$];
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;
  logic m_a = 1'b0, m_b = 1'b0, m_f = 1'b0;

  task automatic check(string tag, logic a, logic b, logic f, logic ea, logic eb, logic ef);
    n_chk++;
    if (a !== ea || b !== eb || f !== ef || irq !== ef) begin
      n_bad++;
      $display("FAIL %s: out_a=%b out_b=%b flt=%b irq=%b expected %b %b %b %b",
               tag, a, b, f, irq, ea, eb, ef, ef);
    end
  endtask

  task automatic step(string tag, logic en, logic ra, logic rb,
                      logic sa = 0, logic va = 0, logic sb_ = 0, logic vb = 0,
                      logic clr = 0, logic ia = 1, logic ib = 0);
    exp_t e;
    logic nf;
    @(negedge clk);
    enable = en; ch_a_raw = ra; ch_b_raw = rb;
    frc_a_stb = sa; frc_a_val = va; frc_b_stb = sb_; frc_b_val = vb;
    flt_clr = clr; idle_a = ia; idle_b = ib;
    if (!en) nf = 1'b0;
    else if (m_a != m_b) nf = 1'b1;
    else if (clr) nf = 1'b0;
    else nf = m_f;
    m_a = sa ? va : ra;
    m_b = sb_ ? vb : rb;
    m_f = nf;
    e.tag = tag;
    e.ef  = nf;
    e.ea  = !en ? ra : (nf ? ia : m_a);
    e.eb  = !en ? rb : (nf ? ib : m_b);
    sb.push_back(e);
  endtask

  always @(posedge clk) begin
    #2;
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      check(e.tag, out_a, out_b, flt, e.ea, e.eb, e.ef);
    end
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    check("R1 reset", out_a, out_b, flt, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    // R2: matching patterns pass with one cycle latency
    step("R2", 1, 1, 1);
    step("R2", 1, 0, 0);
    step("R2", 1, 1, 1);
    step("R2", 1, 1, 1);
    step("R2", 1, 0, 0);
    // R3/R5/R6: one-cycle mismatch, fault the clock after capture
    step("R3", 1, 1, 0);
    step("R3 R5 R6", 1, 0, 0);
    // R4: sticky while raw varies
    step("R4 sticky", 1, 1, 1);
    step("R4 sticky", 1, 0, 0, .ia(0), .ib(1));
    step("R5 idle", 1, 1, 1, .ia(1), .ib(1));
    step("R4 clear", 1, 1, 1, .clr(1));
    step("R2 after clear", 1, 0, 0);
    // R4: set has priority over clear
    step("R4 prio", 1, 0, 1);
    step("R4 prio", 1, 1, 1, .clr(1));
    step("R4 prio", 1, 1, 1);
    step("R4 clear", 1, 0, 0, .clr(1));
    // R7: force injection
    step("R7 force", 1, 0, 0, .sa(1), .va(1));
    step("R7 fault", 1, 0, 0);
    step("R4 clear", 1, 1, 1, .clr(1));
    step("R7 both", 1, 0, 0, .sa(1), .va(1), .sb_(1), .vb(1));
    step("R7 b", 1, 1, 1, .sb_(1), .vb(0));
    step("R7 fault b", 1, 1, 1);
    // R8: disable bypasses and drops fault
    step("R8 drop", 0, 1, 0);
    step("R8 bypass", 0, 0, 1);
    step("R8 bypass", 0, 1, 0, .sa(1), .va(0));
    step("R8 bypass", 0, 1, 1);
    step("R2 reenable", 1, 0, 0);
    step("R2", 1, 1, 1);
    @(negedge clk);
    enable = 1'b0; ch_a_raw = 1'b1; ch_b_raw = 1'b0;
    #1;
    check("R8 comb", out_a, out_b, flt, 1'b1, 1'b0, 1'b0);
    repeat (3) @(posedge clk);
    #3;
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule